// File: doc/BRIEF.md
# Bang-Bang Fine Frequency Tuner with Adaptive Step

This block is the fine-resolution loop of a burst-mode all-digital PLL that also has a coarse loop. It stays idle while the coarse loop still reports a frequency error. Once the coarse loop reports zero error, the block acts once at the end of every burst. It takes a single early/late decision, which says whether the last counted oscillator edge arrived before or after the reference edge. It then moves a 9-bit fine DAC code by one step toward the reference edge. Because of this, the final oscillator edge of each burst dithers tightly around the reference edge.

The step starts large, so acquisition is fast. A run of alternating decisions shows that the loop is circling the target. After four such polarity reversals in a row, the step shrinks to a single LSB. This narrows the loop bandwidth and keeps the limit-cycle ripple small. The code holds steady between bursts. It clamps at both ends of its range. When coarse lock is lost, the code returns to mid-scale and the step returns to the large value.

Top module: `bb_fine_tuner`

## Requirements
- R1: After reset the fine code is 256 (mid-scale) and the step size is 8.
- R2: While coarseLocked is 0, the fine code is held at 256 and the step at 8, and burstDone strobes have no effect.
- R3: While coarse lock is held, the fine code changes only in the clock cycle after a sampled burstDone. With no strobe it stays constant.
- R4: On a burst with isLate=1 (oscillator edge after the reference edge) the code rises by the current step. With isLate=0 it falls by the current step. The new value appears one clock after burstDone is sampled.
- R5: An upward step that would pass 511 leaves the code at 511, with no wrap.
- R6: A downward step that would go below 0 leaves the code at 0, with no wrap.
- R7: A burst whose decision differs from the previous burst's decision counts as a reversal. When the fourth consecutive reversal is seen, that burst still uses step 8, and the step becomes 1 from then on. The first burst after lock has no predecessor and is not a reversal.
- R8: A burst whose decision equals the previous one clears the reversal count.
- R9: Once the step is 1 it stays 1 while coarse lock is held. Losing coarse lock restores code 256 and step 8 and forgets the decision history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock |
| rstN | input | 1 | Active-low synchronous reset |
| coarseLocked | input | 1 | 1 when the coarse loop reports zero error |
| burstDone | input | 1 | One-cycle strobe at the end of each burst |
| isLate | input | 1 | Decision qualified by burstDone: 1 = oscillator edge late, 0 = early |
| fineCode | output | 9 | Fine DAC code |
| stepSize | output | 4 | Current step magnitude, 8 or 1 |

## Verification
A long run of identical late decisions, and then a long run of early decisions, drive the code through every high-gain level to both rails. These runs separate correct clamping from wraparound, and they confirm that same-polarity decisions never lower the gain. Alternating patterns broken by one repeated decision show whether the reversal count really needs consecutive reversals. A clean alternation of exactly four and then five bursts after relock places the gain switch at the right burst. Strobes sent while unlocked, and idle gaps while locked, confirm that the code moves only on a qualified burst.

// File: rtl/bb_fine_pkg.sv
package bb_fine_pkg;

  // Per-cycle command from control to datapath
  typedef struct packed {
    logic clear;    // force mid-scale / high gain
    logic advance;  // apply one step this cycle
    logic dirUp;    // 1: increase code, 0: decrease
    logic lowGain;  // use the small step
  } fineCmd_t;

endpackage

// File: rtl/bb_fine_ctrl.sv
module bb_fine_ctrl
  import bb_fine_pkg::*;
#(
  parameter int REV_LIMIT = 4
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     coarseLocked,
  input  logic     burstDone,
  input  logic     isLate,
  output fineCmd_t cmd
);

  localparam int REV_W = $clog2(REV_LIMIT + 1);

  logic             prevLate;
  logic             prevValid;
  logic [REV_W-1:0] revCnt;
  logic             lowGainQ;
  logic             isReversal;

  assign isReversal = prevValid && (isLate != prevLate);

  always_comb begin
    cmd.clear   = !coarseLocked;
    cmd.advance = coarseLocked && burstDone;
    cmd.dirUp   = isLate;
    cmd.lowGain = lowGainQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN || !coarseLocked) begin
      prevLate  <= 1'b0;
      prevValid <= 1'b0;
      revCnt    <= '0;
      lowGainQ  <= 1'b0;
    end else if (burstDone) begin
      prevLate  <= isLate;
      prevValid <= 1'b1;
      if (!lowGainQ) begin
        if (isReversal) begin
          if (revCnt == REV_W'(REV_LIMIT - 1)) begin
            lowGainQ <= 1'b1;
            revCnt   <= '0;
          end else begin
            revCnt <= revCnt + 1'b1;
          end
        end else begin
          revCnt <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/bb_fine_datapath.sv
module bb_fine_datapath
  import bb_fine_pkg::*;
#(
  parameter int CODE_W  = 9,
  parameter int HI_STEP = 8,
  parameter int LO_STEP = 1,
  parameter int STEP_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  fineCmd_t          cmd,
  output logic [CODE_W-1:0] fineCode,
  output logic [STEP_W-1:0] stepSize
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W:0]   MAX_WIDE = (CODE_W+1)'((1 << CODE_W) - 1);

  logic [CODE_W-1:0] codeQ;
  logic [CODE_W-1:0] stepExt;
  logic [CODE_W:0]   upSum;
  logic [CODE_W-1:0] upCode;
  logic [CODE_W-1:0] downCode;
  logic [CODE_W-1:0] nextCode;

  assign stepExt = cmd.lowGain ? CODE_W'(LO_STEP) : CODE_W'(HI_STEP);
  assign upSum   = {1'b0, codeQ} + {1'b0, stepExt};

  always_comb begin
    upCode   = (upSum > MAX_WIDE) ? MAX_WIDE[CODE_W-1:0] : upSum[CODE_W-1:0];
    downCode = (codeQ < stepExt) ? '0 : (codeQ - stepExt);
    nextCode = cmd.dirUp ? upCode : downCode;
  end

  always_ff @(posedge clk) begin
    if (!rstN || cmd.clear) begin
      codeQ <= MID_CODE;
    end else if (cmd.advance) begin
      codeQ <= nextCode;
    end
  end

  assign fineCode = codeQ;
  assign stepSize = cmd.lowGain ? STEP_W'(LO_STEP) : STEP_W'(HI_STEP);

endmodule

// File: rtl/bb_fine_tuner.sv
module bb_fine_tuner
  import bb_fine_pkg::*;
#(
  parameter int CODE_W    = 9,
  parameter int HI_STEP   = 8,
  parameter int LO_STEP   = 1,
  parameter int REV_LIMIT = 4,
  parameter int STEP_W    = $clog2(HI_STEP + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              coarseLocked,
  input  logic              burstDone,
  input  logic              isLate,
  output logic [CODE_W-1:0] fineCode,
  output logic [STEP_W-1:0] stepSize
);

  fineCmd_t cmd;

  bb_fine_ctrl #(.REV_LIMIT(REV_LIMIT)) uCtrl (
    .clk(clk), .rstN(rstN), .coarseLocked(coarseLocked),
    .burstDone(burstDone), .isLate(isLate), .cmd(cmd)
  );

  bb_fine_datapath #(
    .CODE_W(CODE_W), .HI_STEP(HI_STEP), .LO_STEP(LO_STEP), .STEP_W(STEP_W)
  ) uData (
    .clk(clk), .rstN(rstN), .cmd(cmd), .fineCode(fineCode), .stepSize(stepSize)
  );

endmodule

// File: rtl/bb_fine_checker.sv
module bb_fine_checker #(
  parameter int CODE_W  = 9,
  parameter int HI_STEP = 8,
  parameter int LO_STEP = 1,
  parameter int STEP_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              coarseLocked,
  input logic              burstDone,
  input logic              isLate,
  input logic [CODE_W-1:0] fineCode,
  input logic [STEP_W-1:0] stepSize
);

  localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(1 << (CODE_W - 1));
  localparam logic [CODE_W-1:0] MAX_CODE = CODE_W'((1 << CODE_W) - 1);

  assert_unlocked_mid_R2: assert property (@(posedge clk) disable iff (!rstN)
    !coarseLocked |=> (fineCode == MID_CODE) && (stepSize == STEP_W'(HI_STEP)));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && !burstDone) |=> $stable(fineCode));

  assert_late_up_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && burstDone && isLate &&
     ({1'b0, fineCode} + {1'b0, CODE_W'(stepSize)} <= {1'b0, MAX_CODE}))
    |=> fineCode == $past(fineCode) + CODE_W'($past(stepSize)));

  assert_early_down_R4: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && burstDone && !isLate && (fineCode >= CODE_W'(stepSize)))
    |=> fineCode == $past(fineCode) - CODE_W'($past(stepSize)));

  assert_clamp_top_R5: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && burstDone && isLate && fineCode == MAX_CODE)
    |=> fineCode == MAX_CODE);

  assert_clamp_bottom_R6: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && burstDone && !isLate && fineCode == '0)
    |=> fineCode == '0);

  assert_step_legal_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stepSize == STEP_W'(HI_STEP)) || (stepSize == STEP_W'(LO_STEP)));

  assert_low_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (coarseLocked && stepSize == STEP_W'(LO_STEP)) |=> stepSize == STEP_W'(LO_STEP));

endmodule

bind bb_fine_tuner bb_fine_checker #(
  .CODE_W(CODE_W), .HI_STEP(HI_STEP), .LO_STEP(LO_STEP), .STEP_W(STEP_W)
) uChk (
  .clk(clk), .rstN(rstN), .coarseLocked(coarseLocked), .burstDone(burstDone),
  .isLate(isLate), .fineCode(fineCode), .stepSize(stepSize)
);

// File: tb/tb_bb_fine_tuner.sv
`timescale 1ns/1ps
module tb_bb_fine_tuner;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       coarseLocked = 1'b0;
  logic       burstDone = 1'b0;
  logic       isLate = 1'b0;
  logic [8:0] fineCode;
  logic [3:0] stepSize;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench reference state
  int  mCode = 256;
  int  mStep = 8;
  int  mRev = 0;
  bit  mPrev = 0;
  bit  mValid = 0;

  always #4 clk = ~clk;

  bb_fine_tuner dut (
    .clk(clk), .rstN(rstN), .coarseLocked(coarseLocked), .burstDone(burstDone),
    .isLate(isLate), .fineCode(fineCode), .stepSize(stepSize)
  );

  task automatic check(input string tag);
    checks++;
    if (int'(fineCode) != mCode || int'(stepSize) != mStep) begin
      errors++;
      $display("FAIL %s: code=%0d step=%0d expected code=%0d step=%0d",
               tag, fineCode, stepSize, mCode, mStep);
    end
  endtask

  task automatic modelUnlock();
    mCode = 256; mStep = 8; mRev = 0; mValid = 0;
  endtask

  task automatic modelBurst(input bit late);
    if (late) mCode = (mCode + mStep > 511) ? 511 : mCode + mStep;
    else      mCode = (mCode < mStep) ? 0 : mCode - mStep;
    if (mStep == 8) begin
      if (mValid && late != mPrev) begin
        mRev++;
        if (mRev >= 4) mStep = 1;
      end else begin
        mRev = 0;
      end
    end
    mPrev = late; mValid = 1;
  endtask

  // one burst strobe, result sampled at the following falling edge
  task automatic burst(input bit late, input string tag);
    @(negedge clk);
    burstDone = 1'b1; isLate = late;
    @(negedge clk);
    burstDone = 1'b0; isLate = ~late;
    if (coarseLocked) modelBurst(late);
    check(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      isLate = ~isLate;
      check(tag);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset state");

    // strobes while unlocked are ignored
    burst(1'b1, "R2 unlocked late ignored");
    burst(1'b0, "R2 unlocked early ignored");
    burst(1'b1, "R2 unlocked late ignored");

    @(negedge clk); coarseLocked = 1'b1;
    idle(5, "R3 locked idle hold");

    // same-polarity late run to the top rail
    for (int i = 0; i < 34; i++) burst(1'b1, (mCode + 8 > 511) ? "R5 top clamp" : "R4 late step up");
    idle(3, "R3 hold at top");

    // early run to the bottom rail
    for (int i = 0; i < 66; i++) burst(1'b0, (mCode < 8) ? "R6 bottom clamp" : "R4 early step down");

    // broken alternation keeps high gain
    for (int i = 0; i < 10; i++) burst(1'b1, "R4 climb");
    burst(1'b0, "R8 reversal one");
    burst(1'b1, "R8 reversal two");
    burst(1'b0, "R8 reversal three");
    burst(1'b0, "R8 repeat clears count");
    burst(1'b1, "R8 reversal restart");
    burst(1'b0, "R8 reversal restart");
    burst(1'b1, "R8 reversal restart");
    burst(1'b1, "R8 repeat clears again");

    // clean alternation reaches low gain
    burst(1'b0, "R7 reversal one");
    burst(1'b1, "R7 reversal two");
    burst(1'b0, "R7 reversal three");
    burst(1'b1, "R7 fourth reversal switches gain");
    for (int i = 0; i < 6; i++) burst(i % 2 == 0, "R7 small step dither");
    for (int i = 0; i < 5; i++) burst(1'b1, "R9 low gain persists on repeats");
    idle(4, "R3 hold in low gain");

    // lose lock
    @(negedge clk); coarseLocked = 1'b0;
    @(negedge clk); modelUnlock();
    check("R9 unlock restores mid and high gain");
    burst(1'b0, "R2 unlocked burst ignored");

    // relock, first burst has no predecessor
    @(negedge clk); coarseLocked = 1'b1;
    burst(1'b1, "R7 first burst not a reversal");
    burst(1'b0, "R7 reversal one after relock");
    burst(1'b1, "R7 reversal two after relock");
    burst(1'b0, "R7 reversal three after relock");
    burst(1'b1, "R7 reversal four after relock");
    burst(1'b0, "R7 low gain applied");

    // back-to-back strobes
    @(negedge clk);
    burstDone = 1'b1; isLate = 1'b1;
    @(negedge clk);
    modelBurst(1'b1); check("R4 consecutive strobe one");
    isLate = 1'b1;
    @(negedge clk);
    burstDone = 1'b0;
    modelBurst(1'b1); check("R4 consecutive strobe two");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule